// File: doc/BRIEF.md
# Width-Packing DMA FIFO Buffer

This block sits between a narrow external data port and a wide internal word path. It queues six internal-width words. In the receive direction it packs 16-bit or 32-bit external transfers into 32-bit or 48-bit internal words. In the transmit direction it splits internal words back into external pieces.

The direction, the packing mode, the 16-bit piece order and the data type come from static configuration inputs. The block reports a two-bit fill code and a two-bit packing-stage code. It drives a direction-dependent single-word interrupt, and it accepts a flush request that acts after a fixed delay. Address generation, chaining and bus arbitration belong to the surrounding DMA controller.

Partial packing state is kept in a holding register outside the queue, so the fill code counts only complete internal words.

Top module: `wide_pack_fifo`

## Requirements
- R1: The queue holds DEPTH (default 6) internal words. `fifo_status` reads 00 when empty, 11 when holding DEPTH words and 10 otherwise. Code 01 is never driven. The block comes out of reset empty, with `pack_status` 00.
- R2: The queue accepts a push and delivers a pop in the same cycle. In transmit (`cfg_dir`=1), an internal write to a full queue is taken when an external read pops a word in the same cycle, and the fill code stays 11.
- R3: With `cfg_pmode`=00, one external transfer maps to one internal word. With `cfg_instr`=0, bits 47:32 are forced to zero. With `cfg_instr`=1, all 48 bits pass.
- R4: With `cfg_pmode`=01, two 16-bit pieces taken from `ext_wdata[15:0]` form one word in bits 31:0, with bits 47:32 zero. With `cfg_msw_first`=1 the first piece fills bits 31:16; with 0 it fills bits 15:0. `pack_status` reads 01 after the first piece and 00 after the second.
- R5: With `cfg_pmode`=10, three 16-bit pieces form one 48-bit word. Under `cfg_msw_first`=1 the first piece lands in bits 47:32, and under 0 in bits 15:0. `pack_status` steps 01, 10, 00.
- R6: With `cfg_pmode`=11, three 32-bit transfers A, B and C (taken from `ext_wdata[31:0]`) form two 48-bit words: {A, B[31:16]} and then {B[15:0], C}. The first word enters the queue as `pack_status` reaches 10, and the second as it returns to 00.
- R7: `cfg_instr`=1 turns `cfg_pmode`=01 into three-piece 48-bit packing, identical to mode 10.
- R8: In transmit, each internal word is split in the mirror order of R3 to R6. 16-bit pieces appear on `ext_rdata[15:0]` and 32-bit pieces on `ext_rdata[31:0]`, with the upper bits zero. A word moves out of the queue when its first piece is read, and `pack_status` steps the same way as in receive.
- R9: `ext_ready` is low in receive when the next piece would complete a word while the queue is full, and low in transmit when the next piece needs a new word while the queue is empty. An external strobe while `ext_ready` is low has no effect.
- R10: A `flush_req` sampled at clock edge E leaves the state untouched through edges E and E+1. At edge E+2 it empties the queue, discards partial packing state and clears both status codes.
- R11: `irq` is high only when `cfg_irq_en`=1. In receive it is high when the queue is not empty; in transmit it is high when the queue is not full.
- R12: `pack_status` never reads 11. In the two-piece 16/32 mode it never reads 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir | input | 1 | 0 receive (external to internal), 1 transmit |
| cfg_pmode | input | 2 | Packing mode: 00 none, 01 16/32, 10 16/48, 11 32/48 |
| cfg_msw_first | input | 1 | 1 puts the most significant 16-bit piece first |
| cfg_instr | input | 1 | 1 forces 48-bit internal words |
| cfg_irq_en | input | 1 | Single-word interrupt enable |
| flush_req | input | 1 | Flush request, acted on two cycles later |
| ext_wr | input | 1 | External write strobe (receive) |
| ext_wdata | input | 48 | External write data |
| ext_rd | input | 1 | External read strobe (transmit) |
| ext_rdata | output | 48 | External read data (transmit) |
| ext_ready | output | 1 | External side may transfer this cycle |
| int_wr | input | 1 | Internal write strobe (transmit) |
| int_wdata | input | 48 | Internal write word |
| int_rd | input | 1 | Internal read strobe (receive) |
| int_rdata | output | 48 | Queue head word |
| int_ready | output | 1 | Receive: word available; transmit: room for a word |
| fifo_status | output | 2 | Queue fill code |
| pack_status | output | 2 | Packing stage code |
| irq | output | 1 | Single-word interrupt |

## Verification
The hardest state to reach is a stalled partial pack. The queue is full, one 16-bit piece sits in the holding register, and the piece that would complete the word arrives. The bench first packs six complete words, then writes one extra half-word. It then shows that `ext_ready` falls, that a further piece leaves `pack_status` at 01, and that one internal read lets the pending word complete without losing the held half. The 32/48 split across two words, and a flush while a pack is half done, are driven as directed sequences. The bench checks status on each clock in between.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

    localparam int WORD_W = 48;
    localparam int HALF_W = 16;
    localparam int EXT32_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PM_NONE  = 2'b00,
        PM_16_32 = 2'b01,
        PM_16_48 = 2'b10,
        PM_32_48 = 2'b11
    } pmode_t;

    typedef enum logic [1:0] {
        PS_DONE = 2'b00,
        PS_ONE  = 2'b01,
        PS_TWO  = 2'b10
    } pstage_t;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'b00,
        FS_PART  = 2'b10,
        FS_FULL  = 2'b11
    } fstat_t;

    // instruction words always pack to the full internal width
    function automatic pmode_t eff_mode(logic [1:0] pm, logic instr);
        if (pm == 2'b01 && instr)
            return PM_16_48;
        return pmode_t'(pm);
    endfunction

    function automatic logic [1:0] last_stage(pmode_t m);
        case (m)
            PM_NONE:  return 2'd0;
            PM_16_32: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

    function automatic pstage_t next_stage(pstage_t s, pmode_t m);
        logic [1:0] sv;
        sv = s;
        if (sv == last_stage(m))
            return PS_DONE;
        return pstage_t'(sv + 2'd1);
    endfunction

    // 16-bit slot that the current piece occupies
    function automatic logic [1:0] slot16(pstage_t s, pmode_t m, logic msw);
        logic [1:0] sv;
        sv = s;
        return msw ? (last_stage(m) - sv) : sv;
    endfunction

    function automatic word_t put16(word_t w, logic [1:0] idx, logic [HALF_W-1:0] v);
        word_t r;
        r = w;
        case (idx)
            2'd0:    r[15:0]  = v;
            2'd1:    r[31:16] = v;
            default: r[47:32] = v;
        endcase
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] get16(word_t w, logic [1:0] idx);
        case (idx)
            2'd0:    return w[15:0];
            2'd1:    return w[31:16];
            default: return w[47:32];
        endcase
    endfunction

    function automatic fstat_t fifo_code(logic empty, logic full);
        if (empty)
            return FS_EMPTY;
        if (full)
            return FS_FULL;
        return FS_PART;
    endfunction

endpackage

// File: rtl/wpf_store.sv
module wpf_store
    import wpf_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  push,
    input  word_t wdata,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1: the control around the queue never pushes into a full queue alone
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        (push && full) |-> pop);

    // R9: nothing is taken from an empty queue
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    // R2: a simultaneous push and pop on a full queue keeps it full
    p_full_simul_r2: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full && !clr) |=> full);

endmodule

// File: rtl/wpf_pack.sv
module wpf_pack
    import wpf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    active,
    input  pmode_t  mode,
    input  logic    msw,
    input  logic    instr,
    input  logic    wr,
    input  word_t   wdata,
    input  logic    full,
    output logic    ready,
    output logic    push,
    output word_t   word,
    output pstage_t stage
);
    pstage_t s_q;
    word_t   h_q;
    word_t   h_nx;
    word_t   base;
    logic    completes;
    logic    take;

    assign stage = s_q;

    always_comb begin
        completes = (2'(s_q) == last_stage(mode)) || (mode == PM_32_48 && s_q == PS_ONE);
        ready     = active && (!completes || !full);
        take      = wr && ready;
        push      = take && completes;
        h_nx      = h_q;
        word      = '0;
        base      = '0;
        case (mode)
            PM_NONE: begin
                word = instr ? wdata : {{(WORD_W-EXT32_W){1'b0}}, wdata[EXT32_W-1:0]};
                h_nx = '0;
            end
            PM_32_48: begin
                case (s_q)
                    PS_DONE: h_nx = {wdata[31:0], 16'h0};
                    PS_ONE: begin
                        word = {h_q[47:16], wdata[31:16]};
                        h_nx = {wdata[15:0], 32'h0};
                    end
                    default: begin
                        word = {h_q[47:32], wdata[31:0]};
                        h_nx = '0;
                    end
                endcase
            end
            default: begin
                base = (s_q == PS_DONE) ? '0 : h_q;
                base = put16(base, slot16(s_q, mode, msw), wdata[HALF_W-1:0]);
                if (completes) begin
                    word = base;
                    h_nx = '0;
                end else begin
                    h_nx = base;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s_q <= PS_DONE;
            h_q <= '0;
        end else if (take) begin
            s_q <= next_stage(s_q, mode);
            h_q <= h_nx;
        end
    end

    // R12: receive stage stays within the codes its mode allows
    p_rx_stage_legal_r12: assert property (@(posedge clk) disable iff (rst)
        (2'(s_q) != 2'b11) && (mode != PM_16_32 || s_q != PS_TWO));

    // R9: a completed word is only offered when the queue has room
    p_rx_push_room_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

endmodule

// File: rtl/wpf_unpack.sv
module wpf_unpack
    import wpf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    active,
    input  pmode_t  mode,
    input  logic    msw,
    input  logic    instr,
    input  logic    rd,
    input  word_t   head,
    input  logic    empty,
    output logic    ready,
    output logic    pop,
    output word_t   piece,
    output pstage_t stage
);
    pstage_t s_q;
    word_t   hold_q;
    word_t   src;
    logic    needs_pop;
    logic    take;

    assign stage = s_q;

    always_comb begin
        case (mode)
            PM_NONE:  needs_pop = 1'b1;
            PM_32_48: needs_pop = (s_q != PS_TWO);
            default:  needs_pop = (s_q == PS_DONE);
        endcase
        ready = active && (!needs_pop || !empty);
        take  = rd && ready;
        pop   = take && needs_pop;
        src   = (s_q == PS_DONE) ? head : hold_q;
        piece = '0;
        case (mode)
            PM_NONE:
                piece = instr ? head : {{(WORD_W-EXT32_W){1'b0}}, head[EXT32_W-1:0]};
            PM_32_48: begin
                case (s_q)
                    PS_DONE: piece = {16'h0, head[47:16]};
                    PS_ONE:  piece = {16'h0, hold_q[15:0], head[47:32]};
                    default: piece = {16'h0, hold_q[31:0]};
                endcase
            end
            default:
                piece = {32'h0, get16(src, slot16(s_q, mode, msw))};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            s_q    <= PS_DONE;
            hold_q <= '0;
        end else if (take) begin
            s_q <= next_stage(s_q, mode);
            if (needs_pop)
                hold_q <= head;
        end
    end

    // R12: transmit stage stays within the codes its mode allows
    p_tx_stage_legal_r12: assert property (@(posedge clk) disable iff (rst)
        (2'(s_q) != 2'b11) && (mode != PM_16_32 || s_q != PS_TWO));

endmodule

// File: rtl/wpf_flush.sv
module wpf_flush #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic fire
);
    logic [LAT-1:0] sh;

    generate
        if (LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)
                    sh <= '0;
                else
                    sh <= req;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)
                    sh <= '0;
                else
                    sh <= {sh[LAT-2:0], req};
            end
        end
    endgenerate

    assign fire = sh[LAT-1];

endmodule

// File: rtl/wide_pack_fifo.sv
module wide_pack_fifo
    import wpf_pkg::*;
#(
    parameter int DEPTH     = 6,
    parameter int FLUSH_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dir,
    input  logic [1:0]        cfg_pmode,
    input  logic              cfg_msw_first,
    input  logic              cfg_instr,
    input  logic              cfg_irq_en,
    input  logic              flush_req,
    input  logic              ext_wr,
    input  logic [WORD_W-1:0] ext_wdata,
    input  logic              ext_rd,
    output logic [WORD_W-1:0] ext_rdata,
    output logic              ext_ready,
    input  logic              int_wr,
    input  logic [WORD_W-1:0] int_wdata,
    input  logic              int_rd,
    output logic [WORD_W-1:0] int_rdata,
    output logic              int_ready,
    output logic [1:0]        fifo_status,
    output logic [1:0]        pack_status,
    output logic              irq
);
    logic    rx;
    pmode_t  emode;
    logic    clr;
    logic    q_push;
    logic    q_pop;
    word_t   q_wdata;
    word_t   q_head;
    logic    q_empty;
    logic    q_full;
    logic    pk_ready;
    logic    pk_push;
    word_t   pk_word;
    pstage_t pk_stage;
    logic    up_ready;
    logic    up_pop;
    word_t   up_piece;
    pstage_t up_stage;

    assign rx    = !cfg_dir;
    assign emode = eff_mode(cfg_pmode, cfg_instr);

    wpf_flush #(.LAT(FLUSH_LAT)) u_flush (
        .clk  (clk),
        .rst  (rst),
        .req  (flush_req),
        .fire (clr)
    );

    wpf_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .active (rx),
        .mode   (emode),
        .msw    (cfg_msw_first),
        .instr  (cfg_instr),
        .wr     (ext_wr),
        .wdata  (ext_wdata),
        .full   (q_full),
        .ready  (pk_ready),
        .push   (pk_push),
        .word   (pk_word),
        .stage  (pk_stage)
    );

    wpf_unpack u_unpack (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .active (!rx),
        .mode   (emode),
        .msw    (cfg_msw_first),
        .instr  (cfg_instr),
        .rd     (ext_rd),
        .head   (q_head),
        .empty  (q_empty),
        .ready  (up_ready),
        .pop    (up_pop),
        .piece  (up_piece),
        .stage  (up_stage)
    );

    always_comb begin
        if (rx) begin
            q_push  = pk_push;
            q_wdata = pk_word;
            q_pop   = int_rd && !q_empty;
        end else begin
            q_push  = int_wr && (!q_full || up_pop);
            q_wdata = int_wdata;
            q_pop   = up_pop;
        end
    end

    wpf_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (q_push),
        .wdata (q_wdata),
        .pop   (q_pop),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    assign ext_rdata   = up_piece;
    assign ext_ready   = rx ? pk_ready : up_ready;
    assign int_rdata   = q_head;
    assign int_ready   = rx ? !q_empty : !q_full;
    assign fifo_status = fifo_code(q_empty, q_full);
    assign pack_status = rx ? pk_stage : up_stage;
    assign irq         = cfg_irq_en && (rx ? !q_empty : !q_full);

    // R10: once the delayed flush acts, both status codes read zero
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fifo_status == FS_EMPTY && pack_status == PS_DONE));

    // R1: an empty queue raises no receive interrupt and reports code 00
    p_rx_empty_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (rx && !int_ready) |-> (!irq && fifo_status == FS_EMPTY));

endmodule

// File: tb/tb_wide_pack_fifo.sv
module tb_wide_pack_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dir = 1'b0;
    logic [1:0]  cfg_pmode = 2'b00;
    logic        cfg_msw_first = 1'b0;
    logic        cfg_instr = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        flush_req = 1'b0;
    logic        ext_wr = 1'b0;
    logic [47:0] ext_wdata = '0;
    logic        ext_rd = 1'b0;
    logic [47:0] ext_rdata;
    logic        ext_ready;
    logic        int_wr = 1'b0;
    logic [47:0] int_wdata = '0;
    logic        int_rd = 1'b0;
    logic [47:0] int_rdata;
    logic        int_ready;
    logic [1:0]  fifo_status;
    logic [1:0]  pack_status;
    logic        irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    wide_pack_fifo dut (
        .clk(clk), .rst(rst), .cfg_dir(cfg_dir), .cfg_pmode(cfg_pmode),
        .cfg_msw_first(cfg_msw_first), .cfg_instr(cfg_instr), .cfg_irq_en(cfg_irq_en),
        .flush_req(flush_req), .ext_wr(ext_wr), .ext_wdata(ext_wdata), .ext_rd(ext_rd),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready), .int_wr(int_wr), .int_wdata(int_wdata),
        .int_rd(int_rd), .int_rdata(int_rdata), .int_ready(int_ready),
        .fifo_status(fifo_status), .pack_status(pack_status), .irq(irq)
    );

    task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset(logic dir, logic [1:0] pm, logic msw, logic instr, logic ien);
        @(negedge clk);
        rst = 1'b1;
        cfg_dir = dir; cfg_pmode = pm; cfg_msw_first = msw; cfg_instr = instr; cfg_irq_en = ien;
        ext_wr = 0; ext_rd = 0; int_wr = 0; int_rd = 0; flush_req = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ext_write(logic [47:0] d);
        ext_wr = 1'b1; ext_wdata = d;
        @(negedge clk);
        ext_wr = 1'b0;
    endtask

    task automatic int_write(logic [47:0] d);
        int_wr = 1'b1; int_wdata = d;
        @(negedge clk);
        int_wr = 1'b0;
    endtask

    task automatic int_read(output logic [47:0] d);
        d = int_rdata;
        int_rd = 1'b1;
        @(negedge clk);
        int_rd = 1'b0;
    endtask

    task automatic ext_read(output logic [47:0] d);
        d = ext_rdata;
        ext_rd = 1'b1;
        @(negedge clk);
        ext_rd = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R1 reset fifo_status", 48'(fifo_status), 48'h0);
        chk("R1 reset pack_status", 48'(pack_status), 48'h0);
        chk("R11 reset irq rx empty", 48'(irq), 48'h0);
        chk("R9 reset ext_ready", 48'(ext_ready), 48'h1);
        chk("R1 reset int_ready", 48'(int_ready), 48'h0);
    endtask

    task automatic t_no_pack;
        logic [47:0] d;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        ext_write(48'hAABB_CCDD_EEFF);
        int_read(d);
        chk("R3 none data word", d, 48'h0000_CCDD_EEFF);
        do_reset(1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        ext_write(48'hAABB_CCDD_EEFF);
        int_read(d);
        chk("R3 none instruction word", d, 48'hAABB_CCDD_EEFF);
    endtask

    task automatic t_fill;
        logic [47:0] d;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        ext_write(48'h101);
        chk("R1 one word partial", 48'(fifo_status), 48'h2);
        for (int i = 2; i <= 6; i++) ext_write(48'(32'h100 + i));
        chk("R1 six words full", 48'(fifo_status), 48'h3);
        chk("R9 rx full not ready", 48'(ext_ready), 48'h0);
        ext_write(48'h999);
        chk("R9 ignored write keeps full", 48'(fifo_status), 48'h3);
        for (int i = 1; i <= 6; i++) begin
            int_read(d);
            chk("R1 drain order", d, 48'(32'h100 + i));
        end
        chk("R9 ignored write absent, empty", 48'(fifo_status), 48'h0);
    endtask

    task automatic t_rx_simul;
        logic [47:0] d;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i <= 3; i++) ext_write(48'(32'h200 + i));
        d = int_rdata;
        ext_wr = 1'b1; ext_wdata = 48'h2AA; int_rd = 1'b1;
        @(negedge clk);
        ext_wr = 1'b0; int_rd = 1'b0;
        chk("R2 rx simul head", d, 48'h201);
        chk("R2 rx simul status", 48'(fifo_status), 48'h2);
        int_read(d); chk("R2 rx after simul 1", d, 48'h202);
        int_read(d); chk("R2 rx after simul 2", d, 48'h203);
        int_read(d); chk("R2 rx after simul 3", d, 48'h2AA);
        chk("R2 rx simul drained", 48'(fifo_status), 48'h0);
    endtask

    task automatic t_tx_simul;
        logic [47:0] d;
        do_reset(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i <= 6; i++) int_write(48'(32'h300 + i));
        chk("R1 tx full", 48'(fifo_status), 48'h3);
        chk("R9 tx int_ready full", 48'(int_ready), 48'h0);
        d = ext_rdata;
        int_wr = 1'b1; int_wdata = 48'h307; ext_rd = 1'b1;
        @(negedge clk);
        int_wr = 1'b0; ext_rd = 1'b0;
        chk("R2 tx simul piece", d, 48'h301);
        chk("R2 tx simul stays full", 48'(fifo_status), 48'h3);
        for (int i = 2; i <= 7; i++) begin
            ext_read(d);
            chk("R2 tx drain order", d, 48'(32'h300 + i));
        end
    endtask

    task automatic t_p16_32;
        logic [47:0] d;
        do_reset(1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        ext_write(48'hFFFF_FFFF_1111);
        chk("R4 stage after first", 48'(pack_status), 48'h1);
        chk("R4 partial not counted", 48'(fifo_status), 48'h0);
        ext_write(48'hFFFF_FFFF_2222);
        chk("R4 stage done", 48'(pack_status), 48'h0);
        int_read(d);
        chk("R4 msw first word", d, 48'h0000_1111_2222);
        do_reset(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        ext_write(48'h1111);
        ext_write(48'h2222);
        int_read(d);
        chk("R4 lsw first word", d, 48'h0000_2222_1111);
    endtask

    task automatic t_p16_48;
        logic [47:0] d;
        do_reset(1'b0, 2'b10, 1'b1, 1'b0, 1'b0);
        ext_write(48'hAAAA);
        chk("R5 stage 01", 48'(pack_status), 48'h1);
        ext_write(48'hBBBB);
        chk("R5 stage 10", 48'(pack_status), 48'h2);
        ext_write(48'hCCCC);
        chk("R5 stage 00", 48'(pack_status), 48'h0);
        int_read(d);
        chk("R5 msw first word", d, 48'hAAAA_BBBB_CCCC);
    endtask

    task automatic t_instr;
        logic [47:0] d;
        do_reset(1'b0, 2'b01, 1'b1, 1'b1, 1'b0);
        ext_write(48'h1234);
        ext_write(48'h5678);
        chk("R7 third stage reached", 48'(pack_status), 48'h2);
        chk("R7 nothing queued yet", 48'(fifo_status), 48'h0);
        ext_write(48'h9ABC);
        int_read(d);
        chk("R7 forced 48-bit word", d, 48'h1234_5678_9ABC);
    endtask

    task automatic t_p32_48;
        logic [47:0] d;
        do_reset(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        ext_write(48'hFFFF_1111_2222);
        chk("R6 stage 01", 48'(pack_status), 48'h1);
        chk("R6 empty after first", 48'(fifo_status), 48'h0);
        ext_write(48'hFFFF_3333_4444);
        chk("R6 stage 10", 48'(pack_status), 48'h2);
        chk("R6 first word queued", 48'(fifo_status), 48'h2);
        ext_write(48'hFFFF_5555_6666);
        chk("R6 stage 00", 48'(pack_status), 48'h0);
        int_read(d); chk("R6 word one", d, 48'h1111_2222_3333);
        int_read(d); chk("R6 word two", d, 48'h4444_5555_6666);
    endtask

    task automatic t_rx_backpressure;
        logic [47:0] d;
        do_reset(1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            ext_write(48'(2 * i + 1));
            ext_write(48'(2 * i + 2));
        end
        chk("R1 packed words full", 48'(fifo_status), 48'h3);
        chk("R9 first piece allowed", 48'(ext_ready), 48'h1);
        ext_write(48'hAAAA);
        chk("R9 held piece stage", 48'(pack_status), 48'h1);
        chk("R9 completing piece blocked", 48'(ext_ready), 48'h0);
        ext_write(48'hBBBB);
        chk("R9 blocked piece ignored", 48'(pack_status), 48'h1);
        int_read(d);
        chk("R9 oldest word", d, 48'h0000_0001_0002);
        chk("R9 ready after pop", 48'(ext_ready), 48'h1);
        ext_write(48'hCCCC);
        chk("R9 pack completes", 48'(pack_status), 48'h0);
        for (int i = 1; i < 6; i++) begin
            int_read(d);
            chk("R9 queued word", d, {16'h0, 16'(2 * i + 1), 16'(2 * i + 2)});
        end
        int_read(d);
        chk("R9 held half kept", d, 48'h0000_AAAA_CCCC);
    endtask

    task automatic t_tx_unpack16;
        logic [47:0] d;
        do_reset(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        int_write(48'hAAAA_BBBB_CCCC);
        chk("R8 tx word queued", 48'(fifo_status), 48'h2);
        ext_read(d);
        chk("R8 lsw piece first", d, 48'h0000_0000_CCCC);
        chk("R8 stage 01", 48'(pack_status), 48'h1);
        chk("R8 held word not counted", 48'(fifo_status), 48'h0);
        ext_read(d);
        chk("R8 middle piece", d, 48'h0000_0000_BBBB);
        chk("R8 stage 10", 48'(pack_status), 48'h2);
        ext_read(d);
        chk("R8 last piece", d, 48'h0000_0000_AAAA);
        chk("R8 stage 00", 48'(pack_status), 48'h0);
        chk("R9 tx empty not ready", 48'(ext_ready), 48'h0);
    endtask

    task automatic t_tx_32_48;
        logic [47:0] d;
        do_reset(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        int_write(48'h1111_2222_3333);
        int_write(48'h4444_5555_6666);
        ext_read(d); chk("R8 32/48 piece A", d, 48'h0000_1111_2222);
        chk("R8 32/48 stage 01", 48'(pack_status), 48'h1);
        ext_read(d); chk("R8 32/48 piece B", d, 48'h0000_3333_4444);
        chk("R8 32/48 stage 10", 48'(pack_status), 48'h2);
        ext_read(d); chk("R8 32/48 piece C", d, 48'h0000_5555_6666);
        chk("R8 32/48 stage 00", 48'(pack_status), 48'h0);
    endtask

    task automatic t_tx_empty;
        logic [47:0] d;
        do_reset(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
        chk("R9 tx empty ready low", 48'(ext_ready), 48'h0);
        ext_read(d);
        chk("R9 tx empty read ignored", 48'(pack_status), 48'h0);
        int_write(48'h0000_1234_5678);
        ext_read(d);
        chk("R8 16/32 msw piece", d, 48'h1234);
        ext_read(d);
        chk("R8 16/32 lsw piece", d, 48'h5678);
    endtask

    task automatic t_irq;
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R11 rx empty no irq", 48'(irq), 48'h0);
        ext_write(48'h1);
        chk("R11 rx data irq", 48'(irq), 48'h1);
        do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        ext_write(48'h1);
        chk("R11 disabled no irq", 48'(irq), 48'h0);
        do_reset(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R11 tx empty irq", 48'(irq), 48'h1);
        for (int i = 0; i < 6; i++) int_write(48'(i));
        chk("R11 tx full no irq", 48'(irq), 48'h0);
    endtask

    task automatic t_flush;
        logic [47:0] d;
        do_reset(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        ext_write(48'h1111_2222);
        ext_write(48'h3333_4444);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk("R10 after edge E fifo", 48'(fifo_status), 48'h2);
        chk("R10 after edge E stage", 48'(pack_status), 48'h2);
        @(negedge clk);
        chk("R10 after edge E+1 fifo", 48'(fifo_status), 48'h2);
        chk("R10 after edge E+1 stage", 48'(pack_status), 48'h2);
        @(negedge clk);
        chk("R10 cleared fifo", 48'(fifo_status), 48'h0);
        chk("R10 cleared stage", 48'(pack_status), 48'h0);
        ext_write(48'hAAAA_BBBB);
        ext_write(48'hCCCC_DDDD);
        int_read(d);
        chk("R10 fresh pack after flush", d, 48'hAAAA_BBBB_CCCC);
    endtask

    initial begin
        t_reset_state();
        t_no_pack();
        t_fill();
        t_rx_simul();
        t_tx_simul();
        t_p16_32();
        t_p16_48();
        t_instr();
        t_p32_48();
        t_rx_backpressure();
        t_tx_unpack16();
        t_tx_32_48();
        t_tx_empty();
        t_irq();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule